// File: doc/BRIEF.md
# Tile Depth and Color Buffer

This block keeps the depth and color of every pixel of one screen tile in on-chip storage. A per-tile rasterizer hands it fragments, each carrying a pixel position inside the tile, a depth and a color. The block compares the fragment depth with the depth already held for that pixel. Only a strictly nearer fragment replaces the stored pair.

A tile begins with a start pulse that carries a clear color. The pulse resets the whole tile in a single cycle: every depth becomes all ones and every color becomes the clear color. When the rasterizer has sent its last primitive it raises an end pulse, together with a flag that says whether depth is wanted off chip for this frame. The block then stops taking fragments and streams the tile over a valid/ready write port. It sends all color words in raster order first, then all depth words if the flag was set. A one-cycle done pulse closes the tile.

Depth is never fetched from outside the block. It leaves the chip only through the optional depth pass of the flush.

Top module: `tzb_tile_buffer`

## Requirements
- R1: While reset is held and in the first cycles after it, `frag_ready`, `fb_valid` and `flush_done` are all 0.
- R2: A `tile_start` pulse in the idle state starts a tile. From the next cycle, every pixel that no fragment has won reads as depth 0xFFFF and the `clear_color` sampled with the pulse, and `frag_ready` is 1.
- R3: A fragment replaces the stored depth and color only when its depth is strictly less than the stored depth. An equal or larger depth leaves the pixel unchanged, which includes depth 0xFFFF on a cleared pixel.
- R4: Fragments accepted on consecutive cycles for the same pixel are resolved in arrival order. Each one is compared against the result left by the one before it.
- R5: The pixel index is `{frag_y, frag_x}`, that is y*16+x. A flush first emits 256 words with `fb_is_depth`=0, for indices 0 to 255 in order, each carrying the stored color.
- R6: If `depth_rb` was 1 in the `tile_end` cycle, the color words are followed by 256 words with `fb_is_depth`=1, for indices 0 to 255, each carrying the stored depth zero-extended to 32 bits. If it was 0, no depth word is emitted.
- R7: While `fb_valid` is 1 and `fb_ready` is 0, `fb_idx`, `fb_is_depth` and `fb_data` hold their values into the next cycle and `fb_valid` stays 1.
- R8: `frag_ready` is 1 only while a tile is active and `tile_end` is low. A fragment offered in the `tile_end` cycle is not taken, and no fragment is taken during a flush. The first flush word is valid in the cycle after `tile_end`.
- R9: `flush_done` is high for exactly the one cycle after the final accepted flush word. From that cycle the block is idle again.
- R10: `tile_end` outside an active tile, and `tile_start` outside the idle state, have no effect on the stored tile or the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tile_start | input | 1 | Starts a tile and clears it (idle only) |
| clear_color | input | 32 | Color loaded into every pixel at tile start |
| tile_end | input | 1 | Ends the tile and starts the flush (active tile only) |
| depth_rb | input | 1 | Also send depth in this flush; sampled with `tile_end` |
| frag_valid | input | 1 | Fragment offered |
| frag_ready | output | 1 | Fragment accepted when high together with `frag_valid` |
| frag_x | input | 4 | Pixel column within the tile |
| frag_y | input | 4 | Pixel row within the tile |
| frag_z | input | 16 | Fragment depth, unsigned, smaller is nearer |
| frag_color | input | 32 | Fragment color |
| fb_valid | output | 1 | Flush word valid |
| fb_ready | input | 1 | Frame-buffer side takes the word |
| fb_idx | output | 8 | Pixel index of the word in raster order |
| fb_is_depth | output | 1 | 1 for a depth word, 0 for a color word |
| fb_data | output | 32 | Color, or depth zero-extended |
| flush_done | output | 1 | One-cycle pulse after the last flush word |

## Verification
The bench builds the block with its default parameters: a 16x16 tile, 16-bit depth and 32-bit color. With that size every flush covers all 256 pixels, so the edge indices 0, 240 and 255 and the full color-then-depth order are compared word by word. The 16-bit depth lets a fragment at 0xFFFF meet the cleared value exactly, which exercises the strict comparison. One random tile confines fragments to a 4x4 corner and uses 4-bit depths. That makes equal depths and same-pixel bursts on consecutive cycles frequent, so the forwarding path across the compare stage is exercised many times.

// File: rtl/tzb_pkg.sv
package tzb_pkg;

  typedef enum logic [1:0] {
    TZ_IDLE  = 2'd0,
    TZ_RUN   = 2'd1,
    TZ_FLUSH = 2'd2
  } tz_state_e;

  // strict nearness test: equal depth never wins
  function automatic logic tz_closer(input logic [31:0] cand, input logic [31:0] held);
    return cand < held;
  endfunction

  // raster index inside the tile: row bits above column bits
  function automatic logic [31:0] tz_raster(input logic [15:0] row, input logic [15:0] col,
                                            input int col_bits);
    return (32'(row) << col_bits) | 32'(col);
  endfunction

endpackage

// File: rtl/tzb_store.sv
module tzb_store #(
  parameter int PIX     = 256,
  parameter int IDX_W   = 8,
  parameter int DEPTH_W = 16,
  parameter int COLOR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [COLOR_W-1:0] clr_color,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [DEPTH_W-1:0] wdepth,
  input  logic [COLOR_W-1:0] wcolor,
  input  logic [IDX_W-1:0]   ra_idx,
  output logic [DEPTH_W-1:0] ra_depth,
  input  logic [IDX_W-1:0]   rb_idx,
  output logic [DEPTH_W-1:0] rb_depth,
  output logic [COLOR_W-1:0] rb_color
);

  logic [DEPTH_W-1:0] zmem [PIX];
  logic [COLOR_W-1:0] cmem [PIX];
  logic [PIX-1:0]     live;
  logic [COLOR_W-1:0] bg_color;

  // a pixel is live once a fragment has won it since the last clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live     <= '0;
      bg_color <= '0;
    end else if (clr) begin
      live     <= '0;
      bg_color <= clr_color;
    end else if (we) begin
      live[waddr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      zmem[waddr] <= wdepth;
      cmem[waddr] <= wcolor;
    end
  end

  assign ra_depth = live[ra_idx] ? zmem[ra_idx] : '1;
  assign rb_depth = live[rb_idx] ? zmem[rb_idx] : '1;
  assign rb_color = live[rb_idx] ? cmem[rb_idx] : bg_color;

endmodule

// File: rtl/tzb_zpipe.sv
module tzb_zpipe
  import tzb_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int DEPTH_W = 16,
  parameter int COLOR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_fire,
  input  logic [IDX_W-1:0]   in_idx,
  input  logic [DEPTH_W-1:0] in_z,
  input  logic [COLOR_W-1:0] in_color,
  input  logic [DEPTH_W-1:0] rd_depth,
  output logic               we,
  output logic [IDX_W-1:0]   waddr,
  output logic [DEPTH_W-1:0] wdepth,
  output logic [COLOR_W-1:0] wcolor,
  output logic               busy,
  output logic               fwd_hit
);

  logic               s1_v;
  logic [IDX_W-1:0]   s1_idx;
  logic [DEPTH_W-1:0] s1_z;
  logic [DEPTH_W-1:0] s1_old;
  logic [COLOR_W-1:0] s1_c;
  logic               s1_win;
  logic [DEPTH_W-1:0] base_z;

  assign s1_win = s1_v && tz_closer(32'(s1_z), 32'(s1_old));

  // the stage-1 write lands on the same edge the next fragment samples
  // storage, so a same-pixel winner is forwarded instead of the stale read
  always_comb begin
    fwd_hit = s1_win && (s1_idx == in_idx);
    base_z  = fwd_hit ? s1_z : rd_depth;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= in_fire;
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      s1_idx <= in_idx;
      s1_z   <= in_z;
      s1_c   <= in_color;
      s1_old <= base_z;
    end
  end

  assign we     = s1_win;
  assign waddr  = s1_idx;
  assign wdepth = s1_z;
  assign wcolor = s1_c;
  assign busy   = s1_v;

endmodule

// File: rtl/tzb_flush.sv
module tzb_flush #(
  parameter int PIX     = 256,
  parameter int IDX_W   = 8,
  parameter int DEPTH_W = 16,
  parameter int COLOR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               with_depth,
  input  logic               fb_ready,
  input  logic [DEPTH_W-1:0] rd_depth,
  input  logic [COLOR_W-1:0] rd_color,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               fb_valid,
  output logic [IDX_W-1:0]   fb_idx,
  output logic               fb_is_depth,
  output logic [COLOR_W-1:0] fb_data,
  output logic               fin,
  output logic               done,
  output logic               want_z
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX - 1);

  logic             act;
  logic             phase_z;
  logic [IDX_W-1:0] cnt;
  logic             done_q;
  logic             beat;
  logic             at_end;

  assign beat   = act && fb_ready;
  assign at_end = (cnt == LAST_IDX);
  // final word of the whole flush
  assign fin    = beat && at_end && (phase_z || !want_z);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= 1'b0;
      phase_z <= 1'b0;
      cnt     <= '0;
      want_z  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !act) begin
        act     <= 1'b1;
        phase_z <= 1'b0;
        cnt     <= '0;
        want_z  <= with_depth;
      end else if (beat) begin
        if (!at_end) begin
          cnt <= cnt + 1'b1;
        end else if (!phase_z && want_z) begin
          phase_z <= 1'b1;
          cnt     <= '0;
        end else begin
          act    <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    fb_data = '0;
    if (phase_z) fb_data[DEPTH_W-1:0] = rd_depth;
    else         fb_data = rd_color;
  end

  assign rd_idx      = cnt;
  assign fb_idx      = cnt;
  assign fb_valid    = act;
  assign fb_is_depth = phase_z;
  assign done        = done_q;

endmodule

// File: rtl/tzb_ctrl.sv
module tzb_ctrl
  import tzb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tile_start,
  input  logic      tile_end,
  input  logic      flush_fin,
  output tz_state_e state,
  output logic      clr_go,
  output logic      flush_go,
  output logic      take_en
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TZ_IDLE;
    end else begin
      unique case (state)
        TZ_IDLE:  if (tile_start) state <= TZ_RUN;
        TZ_RUN:   if (tile_end)   state <= TZ_FLUSH;
        TZ_FLUSH: if (flush_fin)  state <= TZ_IDLE;
        default:                  state <= TZ_IDLE;
      endcase
    end
  end

  assign clr_go   = (state == TZ_IDLE) && tile_start;
  assign flush_go = (state == TZ_RUN) && tile_end;
  assign take_en  = (state == TZ_RUN) && !tile_end;

endmodule

// File: rtl/tzb_tile_buffer.sv
module tzb_tile_buffer
  import tzb_pkg::*;
#(
  parameter int TILE_XB = 4,
  parameter int TILE_YB = 4,
  parameter int DEPTH_W = 16,
  parameter int COLOR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tile_start,
  input  logic [COLOR_W-1:0] clear_color,
  input  logic               tile_end,
  input  logic               depth_rb,
  input  logic               frag_valid,
  output logic               frag_ready,
  input  logic [TILE_XB-1:0] frag_x,
  input  logic [TILE_YB-1:0] frag_y,
  input  logic [DEPTH_W-1:0] frag_z,
  input  logic [COLOR_W-1:0] frag_color,
  output logic               fb_valid,
  input  logic               fb_ready,
  output logic [TILE_XB+TILE_YB-1:0] fb_idx,
  output logic               fb_is_depth,
  output logic [COLOR_W-1:0] fb_data,
  output logic               flush_done
);

  localparam int IDX_W = TILE_XB + TILE_YB;
  localparam int PIX   = 1 << IDX_W;

  // named internal events, also observed by the bound checker
  tz_state_e          state;
  logic               clr_go;
  logic               flush_go;
  logic               take_en;
  logic               frag_fire;
  logic [IDX_W-1:0]   frag_idx;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [DEPTH_W-1:0] wr_z;
  logic [COLOR_W-1:0] wr_c;
  logic [DEPTH_W-1:0] look_z;
  logic [IDX_W-1:0]   out_idx;
  logic [DEPTH_W-1:0] out_z;
  logic [COLOR_W-1:0] out_c;
  logic               pipe_busy;
  logic               fwd_hit;
  logic               flush_fin;
  logic               flush_with_z;
  logic               st_run;

  assign st_run     = (state == TZ_RUN);
  assign frag_ready = take_en;
  assign frag_fire  = frag_valid && take_en;
  assign frag_idx   = IDX_W'(tz_raster(16'(frag_y), 16'(frag_x), TILE_XB));

  tzb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tile_start (tile_start),
    .tile_end   (tile_end),
    .flush_fin  (flush_fin),
    .state      (state),
    .clr_go     (clr_go),
    .flush_go   (flush_go),
    .take_en    (take_en)
  );

  tzb_store #(
    .PIX     (PIX),
    .IDX_W   (IDX_W),
    .DEPTH_W (DEPTH_W),
    .COLOR_W (COLOR_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_go),
    .clr_color (clear_color),
    .we        (wr_en),
    .waddr     (wr_idx),
    .wdepth    (wr_z),
    .wcolor    (wr_c),
    .ra_idx    (frag_idx),
    .ra_depth  (look_z),
    .rb_idx    (out_idx),
    .rb_depth  (out_z),
    .rb_color  (out_c)
  );

  tzb_zpipe #(
    .IDX_W   (IDX_W),
    .DEPTH_W (DEPTH_W),
    .COLOR_W (COLOR_W)
  ) u_zpipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (frag_fire),
    .in_idx   (frag_idx),
    .in_z     (frag_z),
    .in_color (frag_color),
    .rd_depth (look_z),
    .we       (wr_en),
    .waddr    (wr_idx),
    .wdepth   (wr_z),
    .wcolor   (wr_c),
    .busy     (pipe_busy),
    .fwd_hit  (fwd_hit)
  );

  tzb_flush #(
    .PIX     (PIX),
    .IDX_W   (IDX_W),
    .DEPTH_W (DEPTH_W),
    .COLOR_W (COLOR_W)
  ) u_flush (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (flush_go),
    .with_depth  (depth_rb),
    .fb_ready    (fb_ready),
    .rd_depth    (out_z),
    .rd_color    (out_c),
    .rd_idx      (out_idx),
    .fb_valid    (fb_valid),
    .fb_idx      (fb_idx),
    .fb_is_depth (fb_is_depth),
    .fb_data     (fb_data),
    .fin         (flush_fin),
    .done        (flush_done),
    .want_z      (flush_with_z)
  );

endmodule

// File: rtl/tzb_tile_buffer_chk.sv
module tzb_tile_buffer_chk #(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frag_ready,
  input logic               fb_valid,
  input logic               fb_ready,
  input logic [IDX_W-1:0]   fb_idx,
  input logic               fb_is_depth,
  input logic [COLOR_W-1:0] fb_data,
  input logic               flush_done,
  input logic               wr_en,
  input logic               st_run,
  input logic               flush_with_z,
  input logic               pipe_busy
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid && !fb_ready |=> fb_valid && $stable(fb_idx) && $stable(fb_is_depth) && $stable(fb_data));

  p_no_take_in_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> !frag_ready);

  p_flush_starts_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> !pipe_busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  p_done_after_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> $past(fb_valid && fb_ready));

  p_write_in_tile_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> st_run);

  p_depth_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid && fb_is_depth |-> flush_with_z);

  p_color_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_valid) |-> (fb_idx == '0) && !fb_is_depth);

endmodule

bind tzb_tile_buffer tzb_tile_buffer_chk #(
  .IDX_W   (IDX_W),
  .COLOR_W (COLOR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frag_ready   (frag_ready),
  .fb_valid     (fb_valid),
  .fb_ready     (fb_ready),
  .fb_idx       (fb_idx),
  .fb_is_depth  (fb_is_depth),
  .fb_data      (fb_data),
  .flush_done   (flush_done),
  .wr_en        (wr_en),
  .st_run       (st_run),
  .flush_with_z (flush_with_z),
  .pipe_busy    (pipe_busy)
);

// File: tb/tzb_tile_buffer_tb.sv
module tzb_tile_buffer_tb;

  localparam int NP = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tile_start = 1'b0;
  logic [31:0] clear_color = '0;
  logic        tile_end = 1'b0;
  logic        depth_rb = 1'b0;
  logic        frag_valid = 1'b0;
  logic        frag_ready;
  logic [3:0]  frag_x = '0;
  logic [3:0]  frag_y = '0;
  logic [15:0] frag_z = '0;
  logic [31:0] frag_color = '0;
  logic        fb_valid;
  logic        fb_ready = 1'b0;
  logic [7:0]  fb_idx;
  logic        fb_is_depth;
  logic [31:0] fb_data;
  logic        flush_done;

  always #4 clk = ~clk;

  tzb_tile_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .tile_start(tile_start), .clear_color(clear_color),
    .tile_end(tile_end), .depth_rb(depth_rb), .frag_valid(frag_valid),
    .frag_ready(frag_ready), .frag_x(frag_x), .frag_y(frag_y), .frag_z(frag_z),
    .frag_color(frag_color), .fb_valid(fb_valid), .fb_ready(fb_ready),
    .fb_idx(fb_idx), .fb_is_depth(fb_is_depth), .fb_data(fb_data),
    .flush_done(flush_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_tag = "R5";

  // behavioural reference: 0 idle, 1 tile active, 2 flushing
  int          mst = 0;
  logic [15:0] ref_z [NP];
  logic [31:0] ref_c [NP];
  logic [40:0] outq [$];
  bit          exp_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    exp_done = 0;
    if (!rst_n) begin
      mst = 0;
      outq.delete();
    end else begin
      case (mst)
        0: if (tile_start) begin
             for (int i = 0; i < NP; i++) begin
               ref_z[i] = 16'hFFFF;
               ref_c[i] = clear_color;
             end
             mst = 1;
           end
        1: if (tile_end) begin
             for (int i = 0; i < NP; i++) outq.push_back({1'b0, 8'(i), ref_c[i]});
             if (depth_rb)
               for (int i = 0; i < NP; i++) outq.push_back({1'b1, 8'(i), 16'h0, ref_z[i]});
             mst = 2;
           end else if (frag_valid) begin
             int p;
             p = int'(frag_y) * 16 + int'(frag_x);
             if (frag_z < ref_z[p]) begin
               ref_z[p] = frag_z;
               ref_c[p] = frag_color;
             end
           end
        default: if (fb_ready && outq.size() > 0) begin
             void'(outq.pop_front());
             if (outq.size() == 0) begin
               exp_done = 1;
               mst = 0;
             end
           end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ev;
      ev = (mst == 1) && !tile_end;
      chk(frag_ready === ev, "R8 frag_ready", 64'(frag_ready), 64'(ev));
      chk(fb_valid === (outq.size() > 0), "R5 fb_valid", 64'(fb_valid), 64'(outq.size() > 0));
      if (outq.size() > 0 && fb_valid === 1'b1) begin
        string t;
        t = {outq[0][40] ? "R6 " : "R5 ", cur_tag, fb_ready ? "" : " R7"};
        chk(fb_is_depth === outq[0][40], {t, " kind"}, 64'(fb_is_depth), 64'(outq[0][40]));
        chk(fb_idx === outq[0][39:32], {t, " idx"}, 64'(fb_idx), 64'(outq[0][39:32]));
        chk(fb_data === outq[0][31:0], {t, " data"}, 64'(fb_data), 64'(outq[0][31:0]));
      end
      chk(flush_done === exp_done, "R9 flush_done", 64'(flush_done), 64'(exp_done));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic frag(input int x, input int y, input int z, input logic [31:0] c);
    frag_valid = 1'b1;
    frag_x = 4'(x);
    frag_y = 4'(y);
    frag_z = 16'(z);
    frag_color = c;
    step();
    frag_valid = 1'b0;
  endtask

  task automatic begin_tile(input logic [31:0] c);
    tile_start = 1'b1;
    clear_color = c;
    step();
    tile_start = 1'b0;
  endtask

  task automatic end_tile(input bit rb, input bit stall);
    tile_end = 1'b1;
    depth_rb = rb;
    step();
    tile_end = 1'b0;
    depth_rb = 1'b0;
    while (mst != 0) begin
      fb_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      step();
    end
    fb_ready = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=running expected=done");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    @(negedge clk);
    // R1: outputs quiet under reset
    chk(frag_ready === 1'b0, "R1 frag_ready", 64'(frag_ready), 0);
    chk(fb_valid === 1'b0, "R1 fb_valid", 64'(fb_valid), 0);
    chk(flush_done === 1'b0, "R1 flush_done", 64'(flush_done), 0);
    step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    chk(frag_ready === 1'b0, "R1 idle after reset", 64'(frag_ready), 0);
    step();

    // R10: end pulse while idle does nothing
    tile_end = 1'b1;
    depth_rb = 1'b1;
    step();
    tile_end = 1'b0;
    depth_rb = 1'b0;
    step();
    @(negedge clk);
    chk(fb_valid === 1'b0, "R10 idle tile_end", 64'(fb_valid), 0);
    step();

    // tile A: directed depth cases, stalled flush with depth
    cur_tag = "R3 R4 R10";
    begin_tile(32'h1122_3344);
    @(negedge clk);
    chk(frag_ready === 1'b1, "R2 ready after start", 64'(frag_ready), 1);
    step();
    frag(3, 0, 100, 32'hA000_0001);
    frag(3, 0, 100, 32'hA000_0002);   // R3 equal loses
    frag(3, 0, 200, 32'hA000_0003);   // R3 farther loses
    frag(5, 2, 16'hFFFF, 32'hA000_0004); // R3 equal to clear loses
    frag(7, 7, 500, 32'hB000_0001);   // R4 same-pixel burst
    frag(7, 7, 400, 32'hB000_0002);
    frag(7, 7, 450, 32'hB000_0003);
    frag(7, 7, 300, 32'hB000_0004);
    frag(7, 7, 300, 32'hB000_0005);
    tile_start = 1'b1;                // R10 start while active
    clear_color = 32'hDEAD_BEEF;
    frag(0, 15, 10, 32'hC000_0001);
    tile_start = 1'b0;
    frag(15, 15, 1, 32'hC000_0002);
    frag(0, 0, 7, 32'hC000_0003);
    // R8: fragment offered with the end pulse is not taken
    frag_valid = 1'b1;
    frag_x = 4'd1;
    frag_y = 4'd1;
    frag_z = 16'd5;
    frag_color = 32'hEEEE_EEEE;
    end_tile(1'b1, 1'b1);
    frag_valid = 1'b0;

    // tile B: dense random corner, no depth pass
    cur_tag = "R3 R4";
    begin_tile(32'h0000_00FF);
    for (int k = 0; k < 400; k++) begin
      frag(int'($urandom % 4), int'($urandom % 4), int'($urandom % 16), $urandom);
    end
    end_tile(1'b0, 1'b0);

    // tile C: empty tile shows the clear values
    cur_tag = "R2";
    begin_tile(32'h5A5A_A5A5);
    repeat (3) step();
    end_tile(1'b1, 1'b1);

    // tile D: random full-tile fragments, stalled flush with depth
    cur_tag = "R3 R4 R7";
    begin_tile(32'h7777_0000);
    for (int k = 0; k < 300; k++) begin
      frag(int'($urandom % 16), int'($urandom % 16), int'($urandom % 65536), $urandom);
    end
    end_tile(1'b1, 1'b1);

    repeat (3) step();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule